// File: doc/BRIEF.md
# SDRAM Command Timing Guard

The guard sits between the command issuer of an SDRAM controller and the memory command bus. Each clock the issuer presents one requested command with a target bank and an auto-precharge flag. The guard answers in the same cycle. It either grants the command, meaning the command may go onto the bus at the coming clock edge, or it holds the command back because a minimum spacing rule has not yet expired. A command that does not fit the current state of its bank is flagged as a protocol error and never granted.

The guard tracks four banks. Each bank has its own down-counters for the spacing after ACTIVE, after PRECHARGE and after write data. Shared counters cover activates to different banks, the settle time after a mode-register write, and the quiet period after self-refresh exit. All limits are counted in clock cycles.

A two-bit grade input selects one of three speed-grade tables. A CAS-latency input selects 2 or 3 and sets when the data bus is released after PRECHARGE. The guard also produces the write and read data-mask timing from the DQM input.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Reset leaves every bank closed, with every counter expired except the mode-register settle delay. An ACTIVE requested in the first cycle after reset is held. The same ACTIVE is granted in the second cycle.
- R2: A READ or WRITE to a bank is granted no earlier than N cycles after that bank's ACTIVE. N is 3, 2 and 3 for grade codes 0, 1 and 2 (code 3 behaves as code 2).
- R3: A PRECHARGE is granted no earlier than 7, 6 or 6 cycles (grade 0, 1, 2) after that bank's ACTIVE.
- R4: After an explicit PRECHARGE, or a READ with auto-precharge, the bank accepts ACTIVE no earlier than 3, 2 or 3 cycles later (grade 0, 1, 2).
- R5: Two ACTIVEs to the same bank are at least 10, 8 or 9 cycles apart (grade 0, 1, 2).
- R6: Two ACTIVEs to any banks are at least 2 cycles apart in every grade.
- R7: A PRECHARGE to a bank is granted no earlier than 2 cycles after that bank's last granted WRITE.
- R8: A WRITE with auto-precharge closes the bank. Its next ACTIVE waits write recovery plus precharge time: 5, 4 or 5 cycles (grade 0, 1, 2).
- R9: After a granted self-refresh exit (command code 6), only NOP (code 0) is granted. This lasts until the same-bank ACTIVE spacing of R5 has passed. Once it has passed, other commands are granted again.
- R10: MODE REGISTER SET (code 5) is granted only when every bank's precharge time has expired. An ACTIVE following it waits 2 cycles.
- R11: A READ, WRITE or PRECHARGE to a closed bank is a protocol error. So is an ACTIVE to an open bank, and so is a MODE REGISTER SET while any bank is open. In each case proto_err is 1, grant is 0, and bank state is unchanged.
- R12: NOP and power-down exit (code 7) are granted whenever no self-refresh quiet period is running. Column commands to an open bank are granted on consecutive cycles.
- R13: The write mask equals DQM in the same cycle. The read mask equals DQM from two cycles earlier.
- R14: dq_hiz pulses exactly CL cycles after a granted explicit PRECHARGE, where CL is 3 when cas_lat3 is 1 and 2 otherwise.

Command codes: NOP 0, ACTIVE 1, READ 2, WRITE 3, PRECHARGE 4, MODE REGISTER SET 5, self-refresh exit 6, power-down exit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| grade_sel | input | 2 | Speed-grade table select (0, 1, 2; 3 acts as 2) |
| cas_lat3 | input | 1 | 1 selects CAS latency 3, 0 selects 2 |
| req_valid | input | 1 | A command is requested this cycle |
| req_cmd | input | 3 | Requested command code |
| req_bank | input | 2 | Target bank |
| req_autopre | input | 1 | Auto-precharge with READ/WRITE |
| dqm_in | input | 1 | Data mask from the issuer |
| grant | output | 1 | Requested command may issue at this edge |
| proto_err | output | 1 | Requested command violates bank state |
| wr_mask | output | 1 | Mask for write data this cycle |
| rd_mask | output | 1 | Mask for read data this cycle |
| dq_hiz | output | 1 | Data bus released after PRECHARGE |

## Verification
The first stimulus is a directed sequence that walks one bank through activate, column access, write, precharge and re-activate. It then stresses activate spacing across two banks and places self-refresh exit and mode-register writes next to other traffic. The grant edge of each counter is probed one cycle early and exactly on time, which separates an off-by-one count from a correct one.

Next, constrained-random command streams run in every grade, with CAS latency 2 and 3. These streams mix legal and illegal commands, so they tell a wrong grade table or a wrong error decode apart from a wrong counter. Throughout both phases, random DQM values tell the zero-latency and two-cycle mask paths apart.

// File: rtl/sdram_guard_pkg.sv
// Package: command codes, limit table type and counter helpers shared by the
// timing guard. Assumes every limit fits in CW bits and is at least 1.
package sdram_guard_pkg;

    localparam int unsigned CW = 4;

    typedef logic [CW-1:0] cnt_t;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_MRS = 3'd5,
        CMD_SRX = 3'd6,
        CMD_PDX = 3'd7
    } cmd_e;

    // Minimum spacings in cycles for one speed grade.
    typedef struct packed {
        cnt_t act_col;   // ACTIVE to READ/WRITE
        cnt_t act_act;   // ACTIVE to ACTIVE, same bank
        cnt_t act_pre;   // ACTIVE to PRECHARGE
        cnt_t pre_act;   // PRECHARGE to ACTIVE
        cnt_t wr_rec;    // write data to PRECHARGE
        cnt_t act_any;   // ACTIVE to ACTIVE, any bank
        cnt_t wap_act;   // write with auto-precharge to ACTIVE
        cnt_t mrs_act;   // mode-register write to ACTIVE
    } lim_t;

    // Select the limit table for a grade code; code 3 aliases code 2.
    function automatic lim_t grade_limits(input logic [1:0] g);
        lim_t l;
        l.wr_rec  = cnt_t'(2);
        l.act_any = cnt_t'(2);
        l.mrs_act = cnt_t'(2);
        case (g)
            2'd0: begin
                l.act_col = cnt_t'(3);  l.act_act = cnt_t'(10);
                l.act_pre = cnt_t'(7);  l.pre_act = cnt_t'(3);
            end
            2'd1: begin
                l.act_col = cnt_t'(2);  l.act_act = cnt_t'(8);
                l.act_pre = cnt_t'(6);  l.pre_act = cnt_t'(2);
            end
            default: begin
                l.act_col = cnt_t'(3);  l.act_act = cnt_t'(9);
                l.act_pre = cnt_t'(6);  l.pre_act = cnt_t'(3);
            end
        endcase
        l.wap_act = l.wr_rec + l.pre_act;
        return l;
    endfunction

    // Load value so that a spacing of n cycles expires n cycles after issue.
    function automatic cnt_t load_of(input cnt_t n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

    // Saturating down-count.
    function automatic cnt_t count_down(input cnt_t c);
        return (c == '0) ? '0 : c - 1'b1;
    endfunction

endpackage

// File: rtl/sdram_bank_timer.sv
// Per-bank state and spacing counters. Tracks whether the bank is open and
// counts down the ACTIVE, PRECHARGE and write-recovery windows. Assumes `hit`
// is only raised for a command the guard has granted to this bank.
module sdram_bank_timer
    import sdram_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lim_t lim,
    input  logic hit,
    input  cmd_e cmd,
    input  logic autopre,
    output logic open_o,
    output logic act_ok,
    output logic col_ok,
    output logic pre_ok,
    output logic rp_done
);

    cnt_t rcd_q, rc_q, ras_q, rp_q, wr_q;
    logic open_q;

    // Bank open flag and five counters; a granted command reloads them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            rcd_q  <= '0;
            rc_q   <= '0;
            ras_q  <= '0;
            rp_q   <= '0;
            wr_q   <= '0;
        end else begin
            rcd_q <= count_down(rcd_q);
            rc_q  <= count_down(rc_q);
            ras_q <= count_down(ras_q);
            rp_q  <= count_down(rp_q);
            wr_q  <= count_down(wr_q);
            if (hit) begin
                case (cmd)
                    CMD_ACT: begin
                        open_q <= 1'b1;
                        rcd_q  <= load_of(lim.act_col);
                        rc_q   <= load_of(lim.act_act);
                        ras_q  <= load_of(lim.act_pre);
                    end
                    CMD_WR: begin
                        wr_q <= load_of(lim.wr_rec);
                        if (autopre) begin
                            open_q <= 1'b0;
                            rp_q   <= load_of(lim.wap_act);
                        end
                    end
                    CMD_RD: begin
                        if (autopre) begin
                            open_q <= 1'b0;
                            rp_q   <= load_of(lim.pre_act);
                        end
                    end
                    CMD_PRE: begin
                        open_q <= 1'b0;
                        rp_q   <= load_of(lim.pre_act);
                    end
                    default: ;
                endcase
            end
        end
    end

    // Readiness flags derived from state and counters.
    always_comb begin
        open_o  = open_q;
        rp_done = (rp_q == '0);
        act_ok  = !open_q && (rc_q == '0) && rp_done;
        col_ok  = open_q && (rcd_q == '0);
        pre_ok  = open_q && (ras_q == '0) && (wr_q == '0);
    end

    a_r2_no_col_after_act: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd == CMD_ACT) |=> !col_ok);

    a_r4_no_act_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd == CMD_PRE) |=> !act_ok);

endmodule

// File: rtl/sdram_cmd_spacing.sv
// Shared spacing counters: ACTIVE to ACTIVE across banks, mode-register
// settle time and the quiet period after self-refresh exit. Reset leaves the
// mode-register delay pending so the first ACTIVE waits for it.
module sdram_cmd_spacing
    import sdram_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  lim_t lim,
    input  logic act_go,
    input  logic mrs_go,
    input  logic srx_go,
    output logic rrd_ok,
    output logic mrd_ok,
    output logic srx_ok
);

    cnt_t rrd_q, mrd_q, srx_q;

    // Reload on the granted command, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            mrd_q <= load_of(lim.mrs_act);
            srx_q <= '0;
        end else begin
            rrd_q <= act_go ? load_of(lim.act_any) : count_down(rrd_q);
            mrd_q <= mrs_go ? load_of(lim.mrs_act) : count_down(mrd_q);
            srx_q <= srx_go ? load_of(lim.act_act) : count_down(srx_q);
        end
    end

    // Expired-counter flags.
    always_comb begin
        rrd_ok = (rrd_q == '0);
        mrd_ok = (mrd_q == '0);
        srx_ok = (srx_q == '0);
    end

endmodule

// File: rtl/sdram_dq_timing.sv
// Data-bus side timing: write mask with no delay, read mask delayed by a
// fixed latency, and the bus-release pulse CAS-latency cycles after an
// explicit PRECHARGE. Assumes CAS latency is 2 or 3.
module sdram_dq_timing #(
    parameter int unsigned MAX_CL     = 3,
    parameter int unsigned RD_MASK_LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cas_lat3,
    input  logic dqm_in,
    input  logic pre_go,
    output logic wr_mask,
    output logic rd_mask,
    output logic dq_hiz
);

    localparam int unsigned CL_LO = MAX_CL - 1;

    logic [MAX_CL-1:0]      pre_sr;
    logic [RD_MASK_LAT-1:0] dqm_sr;

    // Shift the PRECHARGE marker and the mask through their delay lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_sr <= '0;
            dqm_sr <= '0;
        end else begin
            pre_sr <= {pre_sr[MAX_CL-2:0], pre_go};
            dqm_sr <= {dqm_sr[RD_MASK_LAT-2:0], dqm_in};
        end
    end

    // Tap the delay lines.
    always_comb begin
        wr_mask = dqm_in;
        rd_mask = dqm_sr[RD_MASK_LAT-1];
        dq_hiz  = cas_lat3 ? pre_sr[MAX_CL-1] : pre_sr[CL_LO-1];
    end

endmodule

// File: rtl/sdram_cmd_guard.sv
// Top of the command timing guard. Decodes the requested command, checks the
// bank state for protocol errors and combines the bank and shared counters
// into a same-cycle grant. Assumes grade_sel and cas_lat3 change only while
// the bus is idle and that NBANK is a power of two.
module sdram_cmd_guard
    import sdram_guard_pkg::*;
#(
    parameter int unsigned NBANK  = 4,
    parameter int unsigned BANK_W = $clog2(NBANK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        grade_sel,
    input  logic              cas_lat3,
    input  logic              req_valid,
    input  logic [2:0]        req_cmd,
    input  logic [BANK_W-1:0] req_bank,
    input  logic              req_autopre,
    input  logic              dqm_in,
    output logic              grant,
    output logic              proto_err,
    output logic              wr_mask,
    output logic              rd_mask,
    output logic              dq_hiz
);

    lim_t lim;
    cmd_e cmd;
    logic [NBANK-1:0] b_open, b_act_ok, b_col_ok, b_pre_ok, b_rp_done, b_hit;
    logic rrd_ok, mrd_ok, srx_ok;
    logic cmd_ok, cmd_err;

    // Grade table and command decode.
    always_comb begin
        lim = grade_limits(grade_sel);
        cmd = cmd_e'(req_cmd);
    end

    // One timer per bank.
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign b_hit[b] = grant && (req_bank == BANK_W'(b));
        sdram_bank_timer u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .lim     (lim),
            .hit     (b_hit[b]),
            .cmd     (cmd),
            .autopre (req_autopre),
            .open_o  (b_open[b]),
            .act_ok  (b_act_ok[b]),
            .col_ok  (b_col_ok[b]),
            .pre_ok  (b_pre_ok[b]),
            .rp_done (b_rp_done[b])
        );
    end

    sdram_cmd_spacing u_spacing (
        .clk    (clk),
        .rst_n  (rst_n),
        .lim    (lim),
        .act_go (grant && cmd == CMD_ACT),
        .mrs_go (grant && cmd == CMD_MRS),
        .srx_go (grant && cmd == CMD_SRX),
        .rrd_ok (rrd_ok),
        .mrd_ok (mrd_ok),
        .srx_ok (srx_ok)
    );

    sdram_dq_timing #(.MAX_CL(3), .RD_MASK_LAT(2)) u_dq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cas_lat3 (cas_lat3),
        .dqm_in   (dqm_in),
        .pre_go   (grant && cmd == CMD_PRE),
        .wr_mask  (wr_mask),
        .rd_mask  (rd_mask),
        .dq_hiz   (dq_hiz)
    );

    // Per-command legality and readiness.
    always_comb begin
        cmd_ok  = 1'b0;
        cmd_err = 1'b0;
        case (cmd)
            CMD_NOP: cmd_ok = 1'b1;
            CMD_ACT: begin
                cmd_err = b_open[req_bank];
                cmd_ok  = b_act_ok[req_bank] && rrd_ok && mrd_ok;
            end
            CMD_RD, CMD_WR: begin
                cmd_err = !b_open[req_bank];
                cmd_ok  = b_col_ok[req_bank];
            end
            CMD_PRE: begin
                cmd_err = !b_open[req_bank];
                cmd_ok  = b_pre_ok[req_bank];
            end
            CMD_MRS: begin
                cmd_err = |b_open;
                cmd_ok  = &b_rp_done;
            end
            default: cmd_ok = 1'b1;
        endcase
        if (!srx_ok && cmd != CMD_NOP) cmd_ok = 1'b0;
    end

    // Outputs to the issuer.
    always_comb begin
        grant     = req_valid && cmd_ok && !cmd_err;
        proto_err = req_valid && cmd_err;
    end

    a_r6_act_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == CMD_ACT) |=> !(grant && cmd == CMD_ACT));

    a_r9_srx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && cmd == CMD_SRX) |=> !(grant && cmd != CMD_NOP));

    a_r11_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err |-> !grant);

endmodule

// File: tb/sdram_cmd_guard_tb.sv
module sdram_cmd_guard_tb_top;
    import sdram_guard_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] grade_sel = 2'd0;
    logic cas_lat3 = 1'b0;
    logic req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic [1:0] req_bank = 2'd0;
    logic req_autopre = 1'b0;
    logic dqm_in = 1'b0;
    logic grant, proto_err, wr_mask, rd_mask, dq_hiz;

    always #10 clk = ~clk;

    sdram_cmd_guard dut_i (
        .clk(clk), .rst_n(rst_n), .grade_sel(grade_sel), .cas_lat3(cas_lat3),
        .req_valid(req_valid), .req_cmd(req_cmd), .req_bank(req_bank),
        .req_autopre(req_autopre), .dqm_in(dqm_in), .grant(grant),
        .proto_err(proto_err), .wr_mask(wr_mask), .rd_mask(rd_mask),
        .dq_hiz(dq_hiz)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Grade tables straight from the requirements.
    int T_RCD[3] = '{3, 2, 3};
    int T_RC[3]  = '{10, 8, 9};
    int T_RAS[3] = '{7, 6, 6};
    int T_RP[3]  = '{3, 2, 3};
    int T_DAL[3] = '{5, 4, 5};

    // Reference model kept as issue timestamps.
    int g, now, t_anyact, mrd_rdy, srx_rdy;
    int t_act[4], rp_rdy[4], t_wr[4];
    bit open_m[4];
    logic [2:0] pre_hist;
    logic [1:0] dqm_hist;

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b", tag, what, now, act, exp);
        end
    endtask

    task automatic do_reset(input int grade, input bit cl3);
        g = grade;
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; req_cmd = 3'd0; dqm_in = 1'b0;
        grade_sel = 2'(grade); cas_lat3 = cl3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        now = 0; t_anyact = -100; mrd_rdy = 1; srx_rdy = 0;
        for (int i = 0; i < 4; i++) begin
            t_act[i] = -100; rp_rdy[i] = 0; t_wr[i] = -100; open_m[i] = 1'b0;
        end
        pre_hist = '0; dqm_hist = '0;
    endtask

    task automatic step(input logic [2:0] c, input int b, input bit ap, input string tag);
        bit e_err, e_ok, e_gnt, any_open, all_rp;
        logic dq;
        dq = 1'($urandom_range(0, 1));
        req_valid = 1'b1; req_cmd = c; req_bank = 2'(b); req_autopre = ap; dqm_in = dq;
        #5;
        any_open = 1'b0; all_rp = 1'b1;
        for (int i = 0; i < 4; i++) begin
            any_open |= open_m[i];
            if (now < rp_rdy[i]) all_rp = 1'b0;
        end
        e_err = 1'b0; e_ok = 1'b0;
        case (c)
            CMD_NOP: e_ok = 1'b1;
            CMD_ACT: begin
                e_err = open_m[b];
                e_ok = (now >= t_act[b] + T_RC[g]) && (now >= rp_rdy[b]) &&
                       (now >= t_anyact + 2) && (now >= mrd_rdy);
            end
            CMD_RD, CMD_WR: begin
                e_err = !open_m[b];
                e_ok = (now >= t_act[b] + T_RCD[g]);
            end
            CMD_PRE: begin
                e_err = !open_m[b];
                e_ok = (now >= t_act[b] + T_RAS[g]) && (now >= t_wr[b] + 2);
            end
            CMD_MRS: begin
                e_err = any_open;
                e_ok = all_rp;
            end
            default: e_ok = 1'b1;
        endcase
        if (c != CMD_NOP && now < srx_rdy) e_ok = 1'b0;
        e_gnt = e_ok && !e_err;
        chk(tag, "grant", grant, e_gnt);
        chk(tag, "proto_err", proto_err, e_err);
        chk("R13", "wr_mask", wr_mask, dq);
        chk("R13", "rd_mask", rd_mask, dqm_hist[1]);
        chk("R14", "dq_hiz", dq_hiz, cas_lat3 ? pre_hist[2] : pre_hist[1]);
        @(posedge clk);
        if (e_gnt) begin
            case (c)
                CMD_ACT: begin open_m[b] = 1'b1; t_act[b] = now; t_anyact = now; end
                CMD_WR: begin
                    t_wr[b] = now;
                    if (ap) begin open_m[b] = 1'b0; rp_rdy[b] = now + T_DAL[g]; end
                end
                CMD_RD: if (ap) begin open_m[b] = 1'b0; rp_rdy[b] = now + T_RP[g]; end
                CMD_PRE: begin open_m[b] = 1'b0; rp_rdy[b] = now + T_RP[g]; end
                CMD_MRS: mrd_rdy = now + 2;
                CMD_SRX: srx_rdy = now + T_RC[g];
                default: ;
            endcase
        end
        pre_hist = {pre_hist[1:0], e_gnt && (c == CMD_PRE)};
        dqm_hist = {dqm_hist[0], dq};
        now++;
        @(negedge clk);
    endtask

    task automatic run(input logic [2:0] c, input int b, input bit ap, input int n, input string tag);
        for (int i = 0; i < n; i++) step(c, b, ap, tag);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // Directed corner cases, fastest clock grade, CL=2.
        do_reset(0, 1'b0);
        run(CMD_ACT, 0, 0, 2, "R1");
        run(CMD_RD, 0, 0, 3, "R2");
        step(CMD_RD, 0, 0, "R12");
        step(CMD_WR, 0, 0, "R12");
        step(CMD_PDX, 0, 0, "R12");
        run(CMD_PRE, 0, 0, 1, "R7");
        run(CMD_PRE, 0, 0, 3, "R3");
        run(CMD_ACT, 0, 0, 4, "R4");
        run(CMD_ACT, 1, 0, 1, "R6");
        run(CMD_ACT, 2, 0, 2, "R6");
        run(CMD_ACT, 0, 0, 9, "R5");
        step(CMD_RD, 3, 0, "R11");
        step(CMD_ACT, 1, 0, "R11");
        step(CMD_MRS, 0, 0, "R11");
        run(CMD_WR, 1, 1, 2, "R8");
        run(CMD_ACT, 1, 0, 6, "R8");
        run(CMD_RD, 2, 1, 2, "R4");
        run(CMD_ACT, 2, 0, 5, "R4");
        for (int b = 0; b < 4; b++) run(CMD_PRE, b, 0, 8, "R10");
        run(CMD_MRS, 0, 0, 2, "R10");
        run(CMD_ACT, 3, 0, 3, "R10");
        step(CMD_SRX, 0, 0, "R9");
        step(CMD_NOP, 0, 0, "R9");
        step(CMD_RD, 3, 0, "R9");
        run(CMD_ACT, 0, 0, 10, "R9");
        // Release timing at CL=3, fast 7.5 ns grade.
        do_reset(1, 1'b1);
        run(CMD_ACT, 0, 0, 2, "R2");
        run(CMD_PRE, 0, 0, 8, "R14");
        run(CMD_NOP, 0, 0, 4, "R14");
        // Constrained-random traffic in every grade and both latencies.
        for (int gr = 0; gr < 3; gr++) begin
            for (int cl = 0; cl < 2; cl++) begin
                do_reset(gr, cl[0]);
                for (int k = 0; k < 1500; k++) begin
                    int c;
                    c = $urandom_range(0, 7);
                    if ((c == CMD_SRX || c == CMD_MRS) && $urandom_range(0, 15) != 0) c = CMD_NOP;
                    step(3'(c), $urandom_range(0, 3), ($urandom_range(0, 3) == 0), "rand");
                end
            end
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #3000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d: actual hung expected done", now);
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule